// File: doc/BRIEF.md
# Indirect Flash Read Transfer Engine

This block moves a programmed run of bytes out of a serial flash into a small local word buffer, from which the host drains it one 32-bit word at a time. The host loads a byte start address and a byte count into registers and then writes the start strobe. The engine asks a flash-read sequencer for one word at a time, stepping the byte address by four, and stores each returned word in the buffer. The host pulls words from a data port. The sequencer itself is outside the block and talks to it over a simple request/response pair.

A fill-level register and a byte watermark let the host decide when to drain. Three write-one-to-clear status bits (transfer complete, watermark, read overflow) feed a masked interrupt output. A sticky done flag in the control register stays set until the host clears it. A cancel strobe abandons a transfer at any point, empties the buffer and returns the engine to idle without reporting completion. When the buffer is full the engine stops issuing requests, so no word is ever lost through its own pacing.

Top module: `ind_read_engine`

## Requirements
- R1: After reset, every register reads zero (control, start address, byte count, watermark, level, status, mask), `irq`, `fl_req` and `rx_avail` are low, and the buffer is empty.
- R2: A 1 written to control bit 0 while idle, with control bit 1 clear, latches the start address (offset 1) and the byte count (offset 2). It then issues exactly ceil(count/4) single-cycle requests at byte addresses start, start+4, and so on. At most one request is outstanding, and a new request is issued only after the response to the previous one.
- R3: Words reach `rx_word` in request order, exactly as delivered, with the first flash byte in bits 7:0. When the count is not a multiple of 4, the final word keeps its count mod 4 low byte lanes and has the upper lanes forced to zero.
- R4: Register offset 4 returns the number of buffered words in bits 15:0. `rx_avail` is high whenever that number is nonzero. `rx_pop` removes the head word.
- R5: While the buffer holds DEPTH words, no request is issued. Fetching resumes once the host drains the buffer, and every word of the transfer arrives.
- R6: A response (`fl_rvalid`) that arrives while the buffer is full sets status bit 12, and that word is discarded, so the level is unchanged.
- R7: When the last word of a transfer is stored, control bit 5 (done) and status bit 2 (complete) are set and the engine goes idle, with control bit 0 reading back busy = 0. Done stays set until a 1 is written to control bit 5. Clearing status does not clear done.
- R8: Status bit 6 is set in every cycle in which 4 x level exceeds the watermark register (offset 3). A clear written to it in a cycle where that condition holds has no effect.
- R9: Status (offset 5) bits clear when a 1 is written to them. `irq` is high when any status bit is set and the mask register (offset 6) has a 1 at the same bit position.
- R10: A 1 written to control bit 1 stops the transfer in the next cycle, empties the buffer, and sets neither done nor complete. A response still in flight when the cancel takes effect is discarded.
- R11: A start written while busy is ignored, and the running transfer keeps its original address and count. A start with a byte count of zero issues no request and sets done and complete at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rx_pop | input | 1 | Remove the head word from the buffer |
| rx_word | output | 32 | Head word of the buffer |
| rx_avail | output | 1 | Buffer holds at least one word |
| fl_req | output | 1 | One-cycle request for a flash word |
| fl_addr | output | AW | Byte address of the requested word |
| fl_rvalid | input | 1 | Response word valid |
| fl_rdata | input | 32 | Response word, first byte in bits 7:0 |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The in-RTL properties check, on every cycle, the pacing rules: a single outstanding request, no request and no buffer write while full, and the engine idling right after a cancel. They also check the status coupling: completion sets done and complete, an overflow response sets bit 12, the watermark flag follows the level, done survives everything but its own clear, and a cancel never produces done. Only the bench scenarios can show the end-to-end data path: the byte order and tail masking of delivered words, the request address sequence, and the loss-free restart after a stall. The same scenarios cover the dropped overflow word, start-while-busy, zero-length transfers, and a cancel that races an in-flight response.

// File: rtl/ire_pkg.sv
package ire_pkg;

  // control bit positions (read back: bit 0 = busy, bit 5 = done)
  localparam int CTRL_START  = 0;
  localparam int CTRL_CANCEL = 1;
  localparam int CTRL_DONE   = 5;

  // status / mask bit positions
  localparam int ST_CMP = 2;
  localparam int ST_WM  = 6;
  localparam int ST_OVF = 12;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_SADDR  = 3'd1,
    RA_NBYTES = 3'd2,
    RA_WMARK  = 3'd3,
    RA_LEVEL  = 3'd4,
    RA_STAT   = 3'd5,
    RA_MASK   = 3'd6
  } reg_idx_e;

  typedef enum logic {FS_IDLE, FS_RUN} fetch_st_e;

  // number of 32-bit words that hold nbytes bytes
  function automatic logic [31:0] word_total(input logic [31:0] nbytes);
    return {2'b00, nbytes[31:2]} + {31'd0, |nbytes[1:0]};
  endfunction

  // byte-lane keep mask for the final word; tail = count mod 4
  function automatic logic [31:0] tail_keep(input logic [1:0] tail);
    case (tail)
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h0000_FFFF;
      2'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // buffered bytes strictly above the byte threshold
  function automatic logic above_mark(input logic [31:0] words, input logic [31:0] mark);
    return {words[29:0], 2'b00} > mark;
  endfunction

endpackage

// File: rtl/ire_fifo.sv
module ire_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign level   = cnt;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R5: the fetch side never writes into a full buffer
  a_r5_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/ire_fetch.sv
module ire_fetch
  import ire_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  logic [AW-1:0] start_addr,
  input  logic [31:0]   nbytes,
  input  logic          buf_full,
  input  logic          fl_rvalid,
  input  logic [31:0]   fl_rdata,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  output logic          busy,
  output logic          push,
  output logic [31:0]   push_word,
  output logic          fin,
  output logic          ovf_evt
);

  fetch_st_e     state_q;
  logic [31:0]   left_q;
  logic [AW-1:0] addr_q, req_addr_q;
  logic [1:0]    tail_q;
  logic          pend_q, req_q;

  logic idle_go, zero_go, accept, last, issue;

  assign idle_go = go && !abort && (state_q == FS_IDLE);
  assign zero_go = idle_go && (nbytes == 32'd0);
  assign accept  = fl_rvalid && pend_q && !buf_full && (state_q == FS_RUN) && !abort;
  assign last    = (left_q == 32'd1);
  assign issue   = (state_q == FS_RUN) && !pend_q && !buf_full && !abort;

  assign push      = accept;
  assign push_word = last ? (fl_rdata & tail_keep(tail_q)) : fl_rdata;
  assign fin       = (accept && last) || zero_go;
  assign ovf_evt   = fl_rvalid && buf_full;
  assign busy      = (state_q == FS_RUN);
  assign fl_req    = req_q;
  assign fl_addr   = req_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      left_q     <= '0;
      addr_q     <= '0;
      req_addr_q <= '0;
      tail_q     <= '0;
      pend_q     <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      req_q <= issue;
      if (abort) begin
        state_q <= FS_IDLE;
        pend_q  <= 1'b0;
      end else if (idle_go && !zero_go) begin
        state_q <= FS_RUN;
        left_q  <= word_total(nbytes);
        addr_q  <= start_addr;
        tail_q  <= nbytes[1:0];
        pend_q  <= 1'b0;
      end else if (state_q == FS_RUN) begin
        if (issue) begin
          pend_q     <= 1'b1;
          req_addr_q <= addr_q;
          addr_q     <= addr_q + AW'(4);
        end
        if (accept) begin
          pend_q <= 1'b0;
          left_q <= left_q - 32'd1;
          if (last) state_q <= FS_IDLE;
        end
      end
    end
  end

  // R2: one request at a time
  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);

  // R5: a request is only issued with a free slot
  a_r5_req_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> !buf_full);

  // R10: cancel leaves the engine idle with nothing requested
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !fl_req));

endmodule

// File: rtl/ire_regs.sv
module ire_regs
  import ire_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          fin,
  input  logic          ovf_evt,
  input  logic [LW-1:0] level,
  output logic          go,
  output logic          abort,
  output logic [AW-1:0] start_addr,
  output logic [31:0]   nbytes,
  output logic          irq
);

  logic [AW-1:0] saddr_q;
  logic [31:0]   nbytes_q, wmark_q;
  logic          st_cmp, st_wm, st_ovf;
  logic          mk_cmp, mk_wm, mk_ovf;
  logic          done_q;
  logic          wr_ctrl, wr_stat, wm_hit, done_clr;
  logic [31:0]   stat_word, mask_word, ctrl_word;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_we && (reg_addr == RA_STAT);
  assign go       = wr_ctrl && reg_wdata[CTRL_START] && !reg_wdata[CTRL_CANCEL];
  assign abort    = wr_ctrl && reg_wdata[CTRL_CANCEL];
  assign done_clr = wr_ctrl && reg_wdata[CTRL_DONE];
  assign wm_hit   = above_mark(32'(level), wmark_q);

  assign start_addr = saddr_q;
  assign nbytes     = nbytes_q;
  assign irq        = (st_cmp && mk_cmp) || (st_wm && mk_wm) || (st_ovf && mk_ovf);

  always_comb begin
    stat_word         = '0;
    stat_word[ST_CMP] = st_cmp;
    stat_word[ST_WM]  = st_wm;
    stat_word[ST_OVF] = st_ovf;
    mask_word         = '0;
    mask_word[ST_CMP] = mk_cmp;
    mask_word[ST_WM]  = mk_wm;
    mask_word[ST_OVF] = mk_ovf;
    ctrl_word            = '0;
    ctrl_word[CTRL_START] = busy;
    ctrl_word[CTRL_DONE]  = done_q;
    case (reg_addr)
      RA_CTRL:   reg_rdata = ctrl_word;
      RA_SADDR:  reg_rdata = 32'(saddr_q);
      RA_NBYTES: reg_rdata = nbytes_q;
      RA_WMARK:  reg_rdata = wmark_q;
      RA_LEVEL:  reg_rdata = {16'd0, 16'(level)};
      RA_STAT:   reg_rdata = stat_word;
      RA_MASK:   reg_rdata = mask_word;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saddr_q  <= '0;
      nbytes_q <= '0;
      wmark_q  <= '0;
      {mk_cmp, mk_wm, mk_ovf} <= '0;
      {st_cmp, st_wm, st_ovf} <= '0;
      done_q   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_SADDR)  saddr_q  <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == RA_NBYTES) nbytes_q <= reg_wdata;
      if (reg_we && reg_addr == RA_WMARK)  wmark_q  <= reg_wdata;
      if (reg_we && reg_addr == RA_MASK) begin
        mk_cmp <= reg_wdata[ST_CMP];
        mk_wm  <= reg_wdata[ST_WM];
        mk_ovf <= reg_wdata[ST_OVF];
      end
      // set has priority over a write-one clear
      st_cmp <= fin     || (st_cmp && !(wr_stat && reg_wdata[ST_CMP]));
      st_wm  <= wm_hit  || (st_wm  && !(wr_stat && reg_wdata[ST_WM]));
      st_ovf <= ovf_evt || (st_ovf && !(wr_stat && reg_wdata[ST_OVF]));
      done_q <= fin     || (done_q && !done_clr);
    end
  end

  // R7: completion raises both done and the complete flag
  a_r7_done_with_complete: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done_q && st_cmp));

  // R7: done only falls through its own clear
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q);

  // R6: an overflow response is flagged
  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> st_ovf);

  // R8: watermark flag follows the buffer level
  a_r8_wm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wm_hit |=> st_wm);

  // R10: a cancel never reports completion
  a_r10_cancel_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !done_q) |=> !done_q);

endmodule

// File: rtl/ind_read_engine.sv
module ind_read_engine #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rx_pop,
  output logic [31:0]   rx_word,
  output logic          rx_avail,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  input  logic          fl_rvalid,
  input  logic [31:0]   fl_rdata,
  output logic          irq
);

  logic          go, abort, busy, fin, ovf_evt, push;
  logic          buf_empty, buf_full;
  logic [31:0]   push_word, nbytes;
  logic [AW-1:0] start_addr;
  logic [LW-1:0] level;

  assign rx_avail = !buf_empty;

  ire_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .fin(fin), .ovf_evt(ovf_evt), .level(level),
    .go(go), .abort(abort), .start_addr(start_addr), .nbytes(nbytes), .irq(irq)
  );

  ire_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .go(go), .abort(abort), .start_addr(start_addr), .nbytes(nbytes),
    .buf_full(buf_full), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
    .fl_req(fl_req), .fl_addr(fl_addr), .busy(busy),
    .push(push), .push_word(push_word), .fin(fin), .ovf_evt(ovf_evt)
  );

  ire_fifo #(.DEPTH(DEPTH), .W(32)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(abort),
    .push(push), .push_data(push_word), .pop(rx_pop),
    .head(rx_word), .empty(buf_empty), .full(buf_full), .level(level)
  );

endmodule

// File: tb/ind_read_engine_tb.sv
module ind_read_engine_tb;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_pop = 1'b0;
  logic [31:0] rx_word;
  logic        rx_avail;
  logic        fl_req;
  logic [31:0] fl_addr;
  logic        fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;
  logic        irq;

  always #10 clk = ~clk;

  ind_read_engine #(.AW(32), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_pop(rx_pop), .rx_word(rx_word), .rx_avail(rx_avail),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
    .irq(irq)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [31:0] exp_q[$];
  logic [31:0] addr_q[$];
  int          req_cnt = 0;
  bit          drain_en = 0;
  bit          inj_pend = 0;
  logic [31:0] inj_data = '0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] fword(input logic [31:0] a);
    return {fbyte(a + 3), fbyte(a + 2), fbyte(a + 1), fbyte(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // flash sequencer model: fixed latency, one response per request
  always @(negedge clk) begin
    fl_rvalid = 1'b0;
    if (inj_pend) begin
      fl_rvalid = 1'b1;
      fl_rdata  = inj_data;
      inj_pend  = 0;
    end else if (m_cnt == 1) begin
      fl_rvalid = 1'b1;
      fl_rdata  = fword(m_addr);
      m_cnt     = 0;
    end else if (m_cnt > 1) begin
      m_cnt--;
    end
    if (fl_req) begin
      req_cnt++;
      m_addr = fl_addr;
      m_cnt  = 3;
      if (addr_q.size() == 0) chk("R2 unexpected request", fl_addr, 32'hFFFF_FFFF);
      else chk("R2 request address", fl_addr, addr_q.pop_front());
    end
  end

  // scoreboard monitor: drains and compares words
  always @(negedge clk) begin
    rx_pop = 1'b0;
    if (drain_en && rx_avail) begin
      if (exp_q.size() == 0) chk("R3 unexpected word", rx_word, 32'hFFFF_FFFF);
      else chk("R3 delivered word", rx_word, exp_q.pop_front());
      rx_pop = 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: pushes expected addresses and words, then starts
  task automatic launch(input logic [31:0] a, input int n);
    int words;
    words = (n + 3) / 4;
    for (int k = 0; k < words; k++) begin
      logic [31:0] w;
      int rem;
      w = fword(a + 32'(4 * k));
      rem = n - 4 * k;
      if (rem < 4) w = w & ((32'h1 << (8 * rem)) - 32'h1);
      exp_q.push_back(w);
      addr_q.push_back(a + 32'(4 * k));
    end
    wr(3'd1, a);
    wr(3'd2, 32'(n));
    wr(3'd0, 32'h1);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 600; i++) begin
      rd(3'd0, v);
      if (v[5]) break;
    end
    chk(tag, 32'(v[5]), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 irq at reset", 32'(irq), 32'h0);
    chk("R1 fl_req at reset", 32'(fl_req), 32'h0);
    chk("R1 rx_avail at reset", 32'(rx_avail), 32'h0);

    // R3/R7/R9: partial tail, completion, interrupt
    drain_en = 1;
    wr(3'd6, 32'h4);
    launch(32'h100, 7);
    wait_done("R7 done after 7-byte read");
    repeat (3) @(negedge clk);
    chk("R3 all words delivered", 32'(exp_q.size()), 32'h0);
    rd(3'd0, v); chk("R7 ctrl: idle and done", v, 32'h20);
    rd(3'd5, v); chk("R7 complete status bit 2", v & 32'h4, 32'h4);
    chk("R9 irq with complete masked in", 32'(irq), 32'h1);
    wr(3'd5, 32'h4);
    rd(3'd5, v); chk("R9 complete cleared by write-one", v & 32'h4, 32'h0);
    chk("R9 irq low after clear", 32'(irq), 32'h0);
    rd(3'd0, v); chk("R7 done survives status clear", v, 32'h20);
    wr(3'd0, 32'h20);
    rd(3'd0, v); chk("R7 done cleared by write-one", v, 32'h0);

    // R2/R11: start while busy is ignored
    base = req_cnt;
    launch(32'h2000, 24);
    repeat (3) @(negedge clk);
    wr(3'd1, 32'h9000);
    wr(3'd0, 32'h1);
    wait_done("R11 original transfer completes");
    repeat (3) @(negedge clk);
    chk("R2 request count for 24 bytes", 32'(req_cnt - base), 32'd6);
    chk("R11 scoreboard empty", 32'(exp_q.size()), 32'h0);
    wr(3'd0, 32'h20);
    wr(3'd5, 32'h1044);

    // R11: zero-length start
    base = req_cnt;
    launch(32'h40, 0);
    wait_done("R11 zero count sets done");
    rd(3'd5, v); chk("R11 zero count sets complete", v & 32'h4, 32'h4);
    chk("R11 zero count issues no request", 32'(req_cnt - base), 32'd0);
    wr(3'd0, 32'h20);
    wr(3'd5, 32'h1044);

    // R4/R5/R6/R8: fill, stall, overflow, watermark
    drain_en = 0;
    wr(3'd3, 32'd8);
    base = req_cnt;
    launch(32'h300, 40);
    repeat (80) @(negedge clk);
    rd(3'd4, v); chk("R4 level register when full", v, 32'(DEPTH));
    chk("R5 requests stop at full", 32'(req_cnt - base), 32'(DEPTH));
    rd(3'd0, v); chk("R5 still busy while stalled", v & 32'h1, 32'h1);
    rd(3'd5, v); chk("R8 watermark bit 6 set", v & 32'h40, 32'h40);
    inj_data = 32'hDEAD_BEEF;
    inj_pend = 1;
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R6 overflow bit 12 set", v & 32'h1000, 32'h1000);
    rd(3'd4, v); chk("R6 level unchanged by overflow", v, 32'(DEPTH));
    wr(3'd5, 32'h40);
    rd(3'd5, v); chk("R8 clear ignored while above mark", v & 32'h40, 32'h40);
    drain_en = 1;
    wait_done("R5 stalled transfer completes");
    repeat (3) @(negedge clk);
    chk("R5 no word lost or added", 32'(exp_q.size()), 32'h0);
    rd(3'd4, v); chk("R4 level zero after drain", v, 32'h0);
    wr(3'd5, 32'h1044);
    rd(3'd5, v); chk("R8 status clears below mark", v, 32'h0);
    wr(3'd0, 32'h20);

    // R10: cancel mid-transfer
    drain_en = 0;
    launch(32'h500, 64);
    repeat (25) @(negedge clk);
    wr(3'd0, 32'h2);
    exp_q.delete(); addr_q.delete();
    repeat (6) @(negedge clk);
    rd(3'd4, v); chk("R10 buffer emptied", v, 32'h0);
    chk("R10 rx_avail low", 32'(rx_avail), 32'h0);
    rd(3'd0, v); chk("R10 idle, done not set", v, 32'h0);
    rd(3'd5, v); chk("R10 complete not set", v & 32'h4, 32'h0);

    // R10: cancel racing an in-flight response
    base = req_cnt;
    launch(32'h600, 16);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (req_cnt > base) break;
    end
    wr(3'd0, 32'h2);
    exp_q.delete(); addr_q.delete();
    repeat (8) @(negedge clk);
    rd(3'd4, v); chk("R10 late response dropped", v, 32'h0);
    chk("R10 rx_avail after late response", 32'(rx_avail), 32'h0);

    // R3: engine usable after cancel
    drain_en = 1;
    launch(32'h700, 10);
    wait_done("R3 transfer after cancel");
    repeat (3) @(negedge clk);
    chk("R3 words after cancel delivered", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule